// File: doc/BRIEF.md
# Parallel Flash Program/Erase Host Engine

This engine sits on the host side of a byte-wide parallel flash bus and carries out whole flash operations on behalf of a requester: programming one byte, erasing the whole chip, or querying whether the low boot region is write-locked. A request is handed over on a valid/ready handshake together with an operation code, a target address, a data byte and a choice of completion-detection method. The engine then issues the fixed unlock command cycles for that operation, each as a chip-select/write-strobe bus cycle whose setup, low and hold widths are counted in clock cycles.

Once the last command cycle is issued, the engine starts reading the flash immediately, without any wait. It decides completion from the status the device returns on the data bus. In one mode it compares bit 7 against the value expected at the end of the operation. In the other mode it compares bit 6 of two consecutive reads. If the poll count reaches a limit given on an input, the engine reports a timeout and goes back to idle. Programs aimed at the boot region are refused while the last lock query reported the region as locked.

Top module: `flprog_host`

## Requirements
- R1: After reset, chip select, write strobe and output enable are all high, the data bus driver is off, `req_ready` is high, no result pulse is raised and `boot_locked_o` is low.
- R2: A program request (op 0) issues exactly four write cycles: 0xAA to 0x5555, 0x55 to 0x2AAA, 0xA0 to 0x5555, then the request data to the request address.
- R3: An erase request (op 1) issues exactly six write cycles: 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x10@0x5555.
- R4: In every write cycle, chip select is low for SETUP_CYC cycles before the write strobe falls. The write strobe then stays low for exactly LOW_CYC cycles, and chip select rises only after the write strobe has risen. Address and data do not change while chip select stays low.
- R5: In bit-7 mode (`req_poll6`=0), polling starts right after the last command cycle by reading the request address. The operation completes on the first read whose bit 7 equals the expected final bit 7: the request data bit 7 for a program, and 1 for an erase.
- R6: In bit-6 mode (`req_poll6`=1), the operation completes on the first read whose bit 6 equals bit 6 of the read just before it. The first poll read can never complete the operation.
- R7: If `poll_limit` poll reads have been made without completion, `timeout_o` pulses for one cycle, `done_o` stays low and the engine returns to idle.
- R8: A lock query (op 2) issues three writes (0xAA@0x5555, 0x55@0x2AAA, 0x90@0x5555) and one read of 0x0002, then three writes (0xAA@0x5555, 0x55@0x2AAA, 0xF0@0x5555). It then pulses `done_o`, and `boot_locked_o` takes bit 0 of that read.
- R9: A program to an address below BOOT_TOP (0x2000) while `boot_locked_o` is high, or any request with op 3, makes no bus cycle and pulses `reject_o` in the cycle after the handshake. A program at BOOT_TOP or above still runs while locked.
- R10: Each accepted request produces exactly one pulse of `done_o`, `timeout_o` or `reject_o`. `req_ready` stays low from acceptance until that pulse, and the bus is idle whenever `req_ready` is high.
- R11: Output enable goes low only while chip select is low and the write strobe is high, and the data bus driver is off during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request accepted when valid |
| req_op | input | 2 | 0 program, 1 erase, 2 lock query, 3 reserved |
| req_poll6 | input | 1 | 1 selects bit-6 comparison polling, 0 bit-7 polling |
| req_addr | input | 16 | Target byte address |
| req_data | input | 8 | Byte to program |
| poll_limit | input | POLL_W | Maximum poll reads before timeout |
| done_o | output | 1 | One-cycle pulse: operation finished |
| timeout_o | output | 1 | One-cycle pulse: poll limit reached |
| reject_o | output | 1 | One-cycle pulse: request refused |
| boot_locked_o | output | 1 | Boot region lock state from the last query |
| fl_addr | output | 16 | Flash address bus |
| fl_dout | output | 8 | Flash write data |
| fl_dq_oe | output | 1 | Host drives the data bus |
| fl_din | input | 8 | Flash read data |
| fl_ce_n | output | 1 | Chip select, active low |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_oe_n | output | 1 | Output enable, active low |

## Verification
The bench places a behavioural flash beside the engine. This model records every write strobe and returns a programmable number of busy status reads, with bit 7 inverted and bit 6 toggling, before it returns the true data. Exact poll read counts catch an engine that starts comparing one read early or late. Bit-6 cases are chosen so that the first real read does and does not match the last busy read, which exposes an engine that lets the very first read complete or that compares against the wrong bit. Locked-boundary programs at 0x1000 and 0x2000, and a reserved op, catch a wrong address bound or a reject path that still drives the bus. Per-clock strobe width and ordering checks catch a write strobe that opens together with chip select or outlives it.

// File: rtl/flprog_pkg.sv
package flprog_pkg;

  typedef enum logic [1:0] {
    OP_PROG  = 2'd0,
    OP_ERASE = 2'd1,
    OP_LOCKQ = 2'd2,
    OP_RSVD  = 2'd3
  } fl_op_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SET, PH_LOW, PH_HLD, PH_GAP
  } fl_phase_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_CMD, ST_POLL
  } fl_state_e;

  typedef struct packed {
    logic        rd;
    logic [15:0] a;
    logic [7:0]  d;
  } fl_step_t;

  localparam logic [15:0] UNLK_A   = 16'h5555;
  localparam logic [15:0] UNLK_B   = 16'h2AAA;
  localparam logic [15:0] LOCK_REG = 16'h0002;

  function automatic logic [2:0] step_total(fl_op_e op);
    case (op)
      OP_PROG:  return 3'd4;
      OP_ERASE: return 3'd6;
      OP_LOCKQ: return 3'd7;
      default:  return 3'd1;
    endcase
  endfunction

  // Bus step idx of the command sequence for op.
  function automatic fl_step_t step_at(fl_op_e op, logic [2:0] idx,
                                       logic [15:0] a, logic [7:0] d);
    fl_step_t s;
    s.rd = 1'b0;
    s.a  = UNLK_A;
    s.d  = 8'hAA;
    case (idx)
      3'd1: begin s.a = UNLK_B; s.d = 8'h55; end
      3'd2: s.d = (op == OP_PROG) ? 8'hA0 : ((op == OP_ERASE) ? 8'h80 : 8'h90);
      3'd3: begin
        if (op == OP_PROG) begin s.a = a; s.d = d; end
        else if (op == OP_LOCKQ) begin s.rd = 1'b1; s.a = LOCK_REG; s.d = 8'h00; end
      end
      3'd4: if (op == OP_ERASE) begin s.a = UNLK_B; s.d = 8'h55; end
      3'd5: begin
        if (op == OP_ERASE) s.d = 8'h10;
        else begin s.a = UNLK_B; s.d = 8'h55; end
      end
      3'd6: s.d = 8'hF0;
      default: ;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/flprog_strobe.sv
module flprog_strobe
  import flprog_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int SETUP_CYC = 2,
  parameter int LOW_CYC   = 3,
  parameter int HOLD_CYC  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          rd_in,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  input  logic [DW-1:0] bus_din,
  output logic          busy,
  output logic          cyc_done,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_dout,
  output logic          bus_dq_oe,
  output logic          bus_ce_n,
  output logic          bus_we_n,
  output logic          bus_oe_n
);
  localparam int MAXC = (SETUP_CYC > LOW_CYC) ?
                        ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC) :
                        ((LOW_CYC > HOLD_CYC) ? LOW_CYC : HOLD_CYC);
  localparam int CW = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] SET_LAST = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] LOW_LAST = CW'(LOW_CYC - 1);
  localparam logic [CW-1:0] HLD_LAST = CW'(HOLD_CYC - 1);

  fl_phase_e     ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] a_q, a_d;
  logic [DW-1:0] d_q, d_d, r_q, r_d;
  logic          rd_q, rd_d;

  always_comb begin
    ph_d = ph_q; cnt_d = cnt_q; a_d = a_q; d_d = d_q; rd_d = rd_q; r_d = r_q;
    case (ph_q)
      PH_IDLE: if (start) begin
        ph_d = PH_SET; cnt_d = '0; a_d = addr_in; d_d = data_in; rd_d = rd_in;
      end
      PH_SET: if (cnt_q == SET_LAST) begin ph_d = PH_LOW; cnt_d = '0; end
              else cnt_d = cnt_q + 1'b1;
      PH_LOW: if (cnt_q == LOW_LAST) begin
                ph_d = PH_HLD; cnt_d = '0;
                if (rd_q) r_d = bus_din;
              end else cnt_d = cnt_q + 1'b1;
      PH_HLD: if (cnt_q == HLD_LAST) begin ph_d = PH_GAP; cnt_d = '0; end
              else cnt_d = cnt_q + 1'b1;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE; cnt_q <= '0; a_q <= '0; d_q <= '0; rd_q <= 1'b0; r_q <= '0;
    end else begin
      ph_q <= ph_d; cnt_q <= cnt_d; a_q <= a_d; d_q <= d_d; rd_q <= rd_d; r_q <= r_d;
    end
  end

  logic sel;
  assign sel       = (ph_q == PH_SET) || (ph_q == PH_LOW) || (ph_q == PH_HLD);
  assign busy      = (ph_q != PH_IDLE);
  assign cyc_done  = (ph_q == PH_GAP);
  assign rdata     = r_q;
  assign bus_addr  = a_q;
  assign bus_dout  = d_q;
  assign bus_ce_n  = !sel;
  assign bus_we_n  = !((ph_q == PH_LOW) && !rd_q);
  assign bus_oe_n  = !((ph_q == PH_LOW) && rd_q);
  assign bus_dq_oe = sel && !rd_q;
endmodule

// File: rtl/flprog_poll_eval.sv
module flprog_poll_eval (
  input  logic       use_b6,
  input  logic [1:0] rd_b76,
  input  logic       exp_b7,
  input  logic       prev_b6,
  input  logic       have_prev,
  output logic       finished
);
  always_comb begin
    if (use_b6) finished = have_prev && (prev_b6 == rd_b76[0]);
    else        finished = (rd_b76[1] == exp_b7);
  end
endmodule

// File: rtl/flprog_host.sv
module flprog_host
  import flprog_pkg::*;
#(
  parameter int          SETUP_CYC = 2,
  parameter int          LOW_CYC   = 3,
  parameter int          HOLD_CYC  = 1,
  parameter int          POLL_W    = 16,
  parameter logic [15:0] BOOT_TOP  = 16'h2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic              req_poll6,
  input  logic [15:0]       req_addr,
  input  logic [7:0]        req_data,
  input  logic [POLL_W-1:0] poll_limit,
  output logic              done_o,
  output logic              timeout_o,
  output logic              reject_o,
  output logic              boot_locked_o,
  output logic [15:0]       fl_addr,
  output logic [7:0]        fl_dout,
  output logic              fl_dq_oe,
  input  logic [7:0]        fl_din,
  output logic              fl_ce_n,
  output logic              fl_we_n,
  output logic              fl_oe_n
);
  // Reset: asserted asynchronously, released on the clock.
  logic rs0_q, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin rs0_q <= 1'b0; rst_q_n <= 1'b0; end
    else        begin rs0_q <= 1'b1; rst_q_n <= rs0_q; end
  end

  fl_state_e         st_q, st_d;
  fl_op_e            op_q, op_d;
  logic [15:0]       addr_q, addr_d;
  logic [7:0]        data_q, data_d;
  logic              p6_q, p6_d, prev_q, prev_d, havep_q, havep_d, lock_q, lock_d;
  logic [2:0]        idx_q, idx_d;
  logic [POLL_W-1:0] pcnt_q, pcnt_d;
  logic              done_q, done_d, to_q, to_d, rej_q, rej_d;

  fl_step_t   step;
  logic [2:0] last_idx;
  logic       sb_start, sb_rd, sb_busy, sb_done, hit;
  logic [7:0] sb_rdata;
  logic [POLL_W:0] pcnt_nx;
  fl_op_e     req_op_e;

  assign req_op_e = fl_op_e'(req_op);
  assign step     = step_at(op_q, idx_q, addr_q, data_q);
  assign last_idx = step_total(op_q) - 3'd1;
  assign sb_start = (st_q != ST_IDLE) && !sb_busy;
  assign sb_rd    = (st_q == ST_POLL) ? 1'b1 : step.rd;
  assign pcnt_nx  = {1'b0, pcnt_q} + 1'b1;

  flprog_strobe #(
    .AW(16), .DW(8), .SETUP_CYC(SETUP_CYC), .LOW_CYC(LOW_CYC), .HOLD_CYC(HOLD_CYC)
  ) u_strobe (
    .clk(clk), .rst_n(rst_q_n), .start(sb_start), .rd_in(sb_rd),
    .addr_in((st_q == ST_POLL) ? addr_q : step.a), .data_in(step.d),
    .bus_din(fl_din), .busy(sb_busy), .cyc_done(sb_done), .rdata(sb_rdata),
    .bus_addr(fl_addr), .bus_dout(fl_dout), .bus_dq_oe(fl_dq_oe),
    .bus_ce_n(fl_ce_n), .bus_we_n(fl_we_n), .bus_oe_n(fl_oe_n)
  );

  flprog_poll_eval u_poll (
    .use_b6(p6_q), .rd_b76(sb_rdata[7:6]),
    .exp_b7((op_q == OP_ERASE) ? 1'b1 : data_q[7]),
    .prev_b6(prev_q), .have_prev(havep_q), .finished(hit)
  );

  always_comb begin
    st_d = st_q; op_d = op_q; addr_d = addr_q; data_d = data_q; p6_d = p6_q;
    prev_d = prev_q; havep_d = havep_q; lock_d = lock_q; idx_d = idx_q; pcnt_d = pcnt_q;
    done_d = 1'b0; to_d = 1'b0; rej_d = 1'b0;
    case (st_q)
      ST_IDLE: if (req_valid) begin
        if ((req_op_e == OP_RSVD) ||
            ((req_op_e == OP_PROG) && lock_q && (req_addr < BOOT_TOP))) begin
          rej_d = 1'b1;
        end else begin
          st_d = ST_CMD; op_d = req_op_e; addr_d = req_addr; data_d = req_data;
          p6_d = req_poll6; idx_d = '0; pcnt_d = '0; havep_d = 1'b0;
        end
      end
      ST_CMD: if (sb_done) begin
        if (step.rd) lock_d = sb_rdata[0];
        if (idx_q == last_idx) begin
          if (op_q == OP_LOCKQ) begin done_d = 1'b1; st_d = ST_IDLE; end
          else st_d = ST_POLL;
        end else idx_d = idx_q + 3'd1;
      end
      ST_POLL: if (sb_done) begin
        if (hit) begin
          done_d = 1'b1; st_d = ST_IDLE;
        end else if (pcnt_nx >= {1'b0, poll_limit}) begin
          to_d = 1'b1; st_d = ST_IDLE;
        end else begin
          pcnt_d = pcnt_nx[POLL_W-1:0]; prev_d = sb_rdata[6]; havep_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      st_q <= ST_IDLE; op_q <= OP_PROG; addr_q <= '0; data_q <= '0; p6_q <= 1'b0;
      prev_q <= 1'b0; havep_q <= 1'b0; lock_q <= 1'b0; idx_q <= '0; pcnt_q <= '0;
      done_q <= 1'b0; to_q <= 1'b0; rej_q <= 1'b0;
    end else begin
      st_q <= st_d; op_q <= op_d; addr_q <= addr_d; data_q <= data_d; p6_q <= p6_d;
      prev_q <= prev_d; havep_q <= havep_d; lock_q <= lock_d; idx_q <= idx_d;
      pcnt_q <= pcnt_d; done_q <= done_d; to_q <= to_d; rej_q <= rej_d;
    end
  end

  assign req_ready     = (st_q == ST_IDLE) && rst_q_n;
  assign done_o        = done_q;
  assign timeout_o     = to_q;
  assign reject_o      = rej_q;
  assign boot_locked_o = lock_q;
endmodule

// File: rtl/flprog_host_chk.sv
module flprog_host_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        done,
  input logic        timeout,
  input logic        reject,
  input logic        ce_n,
  input logic        we_n,
  input logic        oe_n,
  input logic        dq_oe,
  input logic [15:0] addr,
  input logic [7:0]  dout
);
  p_we_inside_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !ce_n);
  p_ce_leads_we_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> $past(!ce_n));
  p_we_rises_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ce_n) |-> $past(we_n));
  p_bus_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && $past(!ce_n)) |-> ($stable(addr) && $stable(dout)));
  p_read_window_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!ce_n && we_n && !dq_oe));
  p_single_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, timeout, reject}));
  p_idle_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ce_n && we_n && oe_n && !dq_oe));
  p_result_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done || timeout) |-> req_ready);
endmodule

bind flprog_host flprog_host_chk u_chk (
  .clk(clk), .rst_n(rst_q_n), .req_ready(req_ready), .done(done_o),
  .timeout(timeout_o), .reject(reject_o), .ce_n(fl_ce_n), .we_n(fl_we_n),
  .oe_n(fl_oe_n), .dq_oe(fl_dq_oe), .addr(fl_addr), .dout(fl_dout)
);

// File: tb/flprog_host_test.sv
module flprog_host_test;
  localparam int CLK_PERIOD = 10;
  localparam int SETUP_CYC  = 2;
  localparam int LOW_CYC    = 3;
  localparam int HOLD_CYC   = 1;

  logic clk, rst_n, req_valid, req_ready, req_poll6;
  logic [1:0] req_op;
  logic [15:0] req_addr, poll_limit, fl_addr;
  logic [7:0] req_data, fl_dout, fl_din;
  logic done_o, timeout_o, reject_o, boot_locked_o, fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n;

  flprog_host #(.SETUP_CYC(SETUP_CYC), .LOW_CYC(LOW_CYC), .HOLD_CYC(HOLD_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_poll6(req_poll6), .req_addr(req_addr), .req_data(req_data),
    .poll_limit(poll_limit), .done_o(done_o), .timeout_o(timeout_o), .reject_o(reject_o),
    .boot_locked_o(boot_locked_o), .fl_addr(fl_addr), .fl_dout(fl_dout),
    .fl_dq_oe(fl_dq_oe), .fl_din(fl_din), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n),
    .fl_oe_n(fl_oe_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int compared = 0, mismatched = 0, cycles = 0;
  bit finished = 0, mon_en = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      chk(0, "watchdog", cycles, 150000);
      finish_run();
    end
  end

  // Behavioural flash device
  logic [15:0] wr_a[$], exp_a[$], rd_last_a;
  logic [7:0]  wr_d[$], exp_d[$], tgt_val;
  int busy_left = 0, rd_cnt = 0;
  bit tog = 0, id_mode = 0, lock_bit = 0;

  always_comb begin
    if (id_mode && fl_addr == 16'h0002) fl_din = {7'b0, lock_bit};
    else if (busy_left > 0)             fl_din = {~tgt_val[7], tog, tgt_val[5:0]};
    else                                fl_din = tgt_val;
  end

  always @(posedge fl_we_n) if (fl_ce_n === 1'b0) begin
    wr_a.push_back(fl_addr);
    wr_d.push_back(fl_dout);
    if (fl_addr == 16'h5555 && fl_dout == 8'h90) id_mode = 1;
    if (fl_dout == 8'hF0) id_mode = 0;
  end

  always @(posedge fl_oe_n) if (fl_ce_n === 1'b0) begin
    rd_cnt++;
    rd_last_a = fl_addr;
    if (busy_left > 0) begin busy_left--; tog = ~tog; end
  end

  // Per-clock protocol reference
  int set_run = 0, low_run = 0;
  bit saw_low = 0;
  always @(negedge clk) if (mon_en) begin
    chk(fl_we_n || !fl_ce_n, "R4 we low outside ce", fl_ce_n, 0);
    chk(fl_oe_n || (!fl_ce_n && fl_we_n && !fl_dq_oe), "R11 read window", fl_dq_oe, 0);
    chk(!req_ready || (fl_ce_n && fl_we_n && fl_oe_n), "R10 bus idle when ready", fl_ce_n, 1);
    chk(int'(done_o) + int'(timeout_o) + int'(reject_o) <= 1, "R10 single result",
        int'(done_o) + int'(timeout_o) + int'(reject_o), 1);
    if (!fl_we_n) begin
      if (!saw_low) chk(set_run == SETUP_CYC, "R4 setup width", set_run, SETUP_CYC);
      saw_low = 1;
      low_run++;
    end else begin
      if (low_run != 0) chk(low_run == LOW_CYC, "R4 strobe width", low_run, LOW_CYC);
      low_run = 0;
      if (!fl_ce_n && fl_oe_n && !saw_low) set_run++;
    end
    if (fl_ce_n) begin set_run = 0; saw_low = 0; end
  end

  bit res_done, res_to, res_rej, ready_bad;

  task automatic run_req(input logic [1:0] op, input bit p6, input logic [15:0] a,
                         input logic [7:0] d, input int limit, input int busy,
                         input logic [7:0] tgt);
    wr_a.delete(); wr_d.delete();
    rd_cnt = 0; busy_left = busy; tog = 0; tgt_val = tgt;
    res_done = 0; res_to = 0; res_rej = 0; ready_bad = 0;
    @(negedge clk);
    req_valid = 1; req_op = op; req_poll6 = p6; req_addr = a; req_data = d;
    poll_limit = 16'(limit);
    chk(req_ready, "R10 ready before request", req_ready, 1);
    @(posedge clk);
    #1 req_valid = 0;
    for (int n = 0; n < 20000; n++) begin
      @(negedge clk);
      if (done_o || timeout_o || reject_o) begin
        res_done = done_o; res_to = timeout_o; res_rej = reject_o;
        break;
      end
      if (req_ready) ready_bad = 1;
    end
    chk(!ready_bad, "R10 ready low while busy", ready_bad, 0);
    chk(res_done || res_to || res_rej, "R10 result pulse", 0, 1);
  endtask

  task automatic check_writes(input string tag);
    chk(wr_a.size() == exp_a.size(), tag, wr_a.size(), exp_a.size());
    for (int i = 0; i < exp_a.size() && i < wr_a.size(); i++) begin
      chk(wr_a[i] == exp_a[i], tag, wr_a[i], exp_a[i]);
      chk(wr_d[i] == exp_d[i], tag, wr_d[i], exp_d[i]);
    end
  endtask

  task automatic exp_w(input logic [15:0] a, input logic [7:0] d);
    exp_a.push_back(a); exp_d.push_back(d);
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_op = 0; req_poll6 = 0; req_addr = 0; req_data = 0;
    poll_limit = 16'd50; tgt_val = 8'hFF;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(fl_ce_n && fl_we_n && fl_oe_n, "R1 strobes idle", {fl_ce_n, fl_we_n, fl_oe_n}, 7);
    chk(!fl_dq_oe, "R1 driver off", fl_dq_oe, 0);
    chk(req_ready, "R1 ready", req_ready, 1);
    chk(!done_o && !timeout_o && !reject_o, "R1 no pulse", done_o, 0);
    chk(!boot_locked_o, "R1 unlocked", boot_locked_o, 0);
    mon_en = 1;

    // R2 + R5: program, bit-7 polling, three busy reads
    run_req(2'd0, 0, 16'h1234, 8'h5A, 50, 3, 8'h5A);
    exp_a.delete(); exp_d.delete();
    exp_w(16'h5555, 8'hAA); exp_w(16'h2AAA, 8'h55); exp_w(16'h5555, 8'hA0); exp_w(16'h1234, 8'h5A);
    check_writes("R2 program sequence");
    chk(res_done, "R5 program done", res_done, 1);
    chk(rd_cnt == 4, "R5 poll reads", rd_cnt, 4);
    chk(rd_last_a == 16'h1234, "R5 poll address", rd_last_a, 16'h1234);

    // R5: bit 7 of data is 1, device already finished
    run_req(2'd0, 0, 16'h4000, 8'hC3, 50, 0, 8'hC3);
    chk(res_done && rd_cnt == 1, "R5 immediate finish", rd_cnt, 1);

    // R3 + R5: erase, expected bit 7 is 1
    run_req(2'd1, 0, 16'h0000, 8'h00, 50, 2, 8'hFF);
    exp_a.delete(); exp_d.delete();
    exp_w(16'h5555, 8'hAA); exp_w(16'h2AAA, 8'h55); exp_w(16'h5555, 8'h80);
    exp_w(16'h5555, 8'hAA); exp_w(16'h2AAA, 8'h55); exp_w(16'h5555, 8'h10);
    check_writes("R3 erase sequence");
    chk(res_done && rd_cnt == 3, "R5 erase poll reads", rd_cnt, 3);

    // R6: bit-6 comparison polling
    run_req(2'd0, 1, 16'h3000, 8'h37, 50, 4, 8'h37);
    chk(res_done && rd_cnt == 6, "R6 toggle then stable 0", rd_cnt, 6);
    run_req(2'd0, 1, 16'h3001, 8'h77, 50, 4, 8'h77);
    chk(res_done && rd_cnt == 5, "R6 real read matches last busy", rd_cnt, 5);
    run_req(2'd0, 1, 16'h3002, 8'h11, 50, 0, 8'h11);
    chk(res_done && rd_cnt == 2, "R6 first read never completes", rd_cnt, 2);
    run_req(2'd1, 1, 16'h0000, 8'h00, 50, 3, 8'hFF);
    chk(res_done && rd_cnt == 5, "R6 erase toggle", rd_cnt, 5);

    // R7: timeout after poll_limit reads
    run_req(2'd0, 0, 16'h5000, 8'h01, 5, 100, 8'h01);
    chk(res_to && !res_done, "R7 timeout pulse", res_to, 1);
    chk(rd_cnt == 5, "R7 read count", rd_cnt, 5);

    // R8: lock query reporting locked
    lock_bit = 1;
    run_req(2'd2, 0, 16'h0000, 8'h00, 50, 0, 8'hFF);
    exp_a.delete(); exp_d.delete();
    exp_w(16'h5555, 8'hAA); exp_w(16'h2AAA, 8'h55); exp_w(16'h5555, 8'h90);
    exp_w(16'h5555, 8'hAA); exp_w(16'h2AAA, 8'h55); exp_w(16'h5555, 8'hF0);
    check_writes("R8 query sequence");
    chk(res_done && rd_cnt == 1 && rd_last_a == 16'h0002, "R8 status read", rd_last_a, 2);
    chk(boot_locked_o, "R8 lock bit", boot_locked_o, 1);

    // R9: locked boot region and reserved op
    run_req(2'd0, 0, 16'h1000, 8'h00, 50, 0, 8'h00);
    chk(res_rej && wr_a.size() == 0 && rd_cnt == 0, "R9 boot program refused", wr_a.size(), 0);
    run_req(2'd0, 0, 16'h1FFF, 8'h00, 50, 0, 8'h00);
    chk(res_rej, "R9 last boot address refused", res_rej, 1);
    run_req(2'd0, 0, 16'h2000, 8'h00, 50, 0, 8'h00);
    chk(res_done && wr_a.size() == 4, "R9 boundary program runs", wr_a.size(), 4);
    run_req(2'd3, 0, 16'h8000, 8'h00, 50, 0, 8'h00);
    chk(res_rej && wr_a.size() == 0, "R9 reserved op refused", wr_a.size(), 0);

    // R8 + R9: query reporting unlocked reopens the boot region
    lock_bit = 0;
    run_req(2'd2, 0, 16'h0000, 8'h00, 50, 0, 8'hFF);
    chk(!boot_locked_o, "R8 unlock read", boot_locked_o, 0);
    run_req(2'd0, 0, 16'h1000, 8'h42, 50, 1, 8'h42);
    chk(res_done && wr_a.size() == 4, "R9 boot program when unlocked", wr_a.size(), 4);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule